// File: doc/BRIEF.md
# Serial Converter Output Port Model

This block is the digital face of a 14-bit sampling converter, written so that it can stand in for the device during verification or run inside an FPGA emulator. The analog conversion is not modelled. A parallel sample word is supplied instead. The block captures that word when the active-low convert-start input falls. It holds busy high for a fixed number of system clock cycles. It then presents the result as a 16-bit serial frame that a host shifts out with its own serial clock.

All inputs are sampled on the system clock, and the serial clock edges are found by comparing each sample with the one before. The frame register has no memory of a finished read. Once 16 pulses have been given, the port releases the data line and counts from the top again. Any accepted convert-start clears the frame register and its bit pointer, even when a read is part way through.

Top module: `adc_serial_out`

## Requirements
- R1: After reset, busy, sdata and sdata_oe are all 0.
- R2: A falling edge on conv_start_n while busy is low sets busy on the next system clock edge. Busy then stays high for exactly CONV_CYCLES system clock cycles.
- R3: After busy falls, 16 serial clock pulses read the frame {2'b00, sample} MSB first. The frame's bit 15 goes out first. Each bit appears one system clock after the serial clock falls.
- R4: The sample is captured from sample_in in the cycle the conversion is accepted. Later changes to sample_in do not alter the frame.
- R5: sdata_oe rises with the first serial clock falling edge of a frame. It falls one system clock after the rising edge of the 16th pulse.
- R6: A 17th pulse does not hold the register. The frame starts over: the data line is driven again, and bit 15 comes first.
- R7: A falling edge on conv_start_n while busy is high is ignored. Busy ends at its original time and the frame keeps the first sample.
- R8: An accepted convert-start during a read turns sdata_oe off on the next clock and resets the bit pointer. Pulses that follow continue from bit 15 of the cleared register.
- R9: From the accepted convert-start until busy falls, the frame register reads as all zeros.
- R10: Holding conv_start_n low does not start another conversion. Only a high-to-low transition does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_start_n | input | 1 | Active-low convert start; its falling edge begins a conversion |
| sample_in | input | SAMPLE_W | Parallel stand-in for the converted value |
| ser_clk | input | 1 | Host serial clock, idles high |
| busy | output | 1 | High while a conversion is in progress |
| sdata | output | 1 | Serial data bit |
| sdata_oe | output | 1 | Drive enable for sdata; low means high impedance |

## Verification
The hardest situations to reach are the ones where two timelines overlap. In one, a convert-start lands in the middle of a serial read. In the other, serial clock pulses arrive while a conversion is still running. The bench drives both clocks from tasks on the falling system clock edge, so it can interleave them at exact cycle positions. In the overlap test it reads five bits, starts a new conversion, and pulses three times during busy. It then checks that the rest of the new frame comes out from bit 12 down. Ignored edges are checked by firing a second convert-start part way through busy and confirming that the busy length and the frame contents do not change.

// File: rtl/adc_serial_out_pkg.sv
package adc_serial_out_pkg;

  typedef enum logic {
    CV_IDLE = 1'b0,
    CV_BUSY = 1'b1
  } conv_state_e;

  // Bit position driven for a given pointer value, MSB first.
  function automatic int unsigned frame_bit_index(input int unsigned ptr,
                                                  input int unsigned frame_w);
    return frame_w - 1 - ptr;
  endfunction

  // Pointer after one completed serial pulse, wrapping at the frame length.
  function automatic int unsigned ptr_advance(input int unsigned ptr,
                                              input int unsigned frame_w);
    return (ptr == frame_w - 1) ? 0 : ptr + 1;
  endfunction

endpackage

// File: rtl/adc_edge_tap.sv
module adc_edge_tap #(
  parameter logic RESET_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic fall_o,
  output logic rise_o
);
  logic level_q;

  always_ff @(posedge clk) begin
    if (!rst_n) level_q <= RESET_LEVEL;
    else        level_q <= level_i;
  end

  assign fall_o = level_q & ~level_i;
  assign rise_o = ~level_q & level_i;
endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer
  import adc_serial_out_pkg::*;
#(
  parameter int unsigned CONV_CYCLES = 500,
  localparam int unsigned CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req_i,
  output logic accept_o,
  output logic done_o,
  output logic busy_o
);
  conv_state_e state_q;
  logic [CNT_W-1:0] left_q;

  assign accept_o = start_req_i && (state_q == CV_IDLE);
  assign done_o   = (state_q == CV_BUSY) && (left_q == '0);
  assign busy_o   = (state_q == CV_BUSY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= CV_IDLE;
      left_q  <= '0;
    end else if (accept_o) begin
      state_q <= CV_BUSY;
      left_q  <= CNT_W'(CONV_CYCLES - 1);
    end else if (done_o) begin
      state_q <= CV_IDLE;
    end else if (state_q == CV_BUSY) begin
      left_q  <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/adc_shift_out.sv
module adc_shift_out
  import adc_serial_out_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 14,
  parameter int unsigned FRAME_W  = 16,
  localparam int unsigned PAD_W   = FRAME_W - SAMPLE_W,
  localparam int unsigned PTR_W   = $clog2(FRAME_W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accept_i,
  input  logic                done_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                sclk_fall_i,
  input  logic                sclk_rise_i,
  output logic                sdata_o,
  output logic                oe_o
);
  logic [SAMPLE_W-1:0] held_q;
  logic [FRAME_W-1:0]  word_q;
  logic [PTR_W-1:0]    ptr_q;

  function automatic logic [FRAME_W-1:0] pack_frame(input logic [SAMPLE_W-1:0] s);
    return {{PAD_W{1'b0}}, s};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q  <= '0;
      word_q  <= '0;
      ptr_q   <= '0;
      sdata_o <= 1'b0;
      oe_o    <= 1'b0;
    end else if (accept_i) begin
      held_q  <= sample_i;
      word_q  <= '0;
      ptr_q   <= '0;
      sdata_o <= 1'b0;
      oe_o    <= 1'b0;
    end else begin
      if (done_i) word_q <= pack_frame(held_q);
      if (sclk_fall_i) begin
        sdata_o <= word_q[frame_bit_index(32'(ptr_q), FRAME_W)];
        oe_o    <= 1'b1;
      end else if (sclk_rise_i) begin
        ptr_q <= PTR_W'(ptr_advance(32'(ptr_q), FRAME_W));
        if (ptr_q == PTR_W'(FRAME_W - 1)) oe_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/adc_serial_out.sv
module adc_serial_out
  import adc_serial_out_pkg::*;
#(
  parameter int unsigned SAMPLE_W    = 14,
  parameter int unsigned FRAME_W     = 16,
  parameter int unsigned CONV_CYCLES = 500
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                conv_start_n,
  input  logic [SAMPLE_W-1:0] sample_in,
  input  logic                ser_clk,
  output logic                busy,
  output logic                sdata,
  output logic                sdata_oe
);
  logic conv_fall;
  logic conv_rise_unused;
  logic conv_accept;
  logic conv_done;
  logic sclk_fall;
  logic sclk_rise;

  adc_edge_tap #(.RESET_LEVEL(1'b1)) conv_tap_i (
    .clk(clk), .rst_n(rst_n), .level_i(conv_start_n),
    .fall_o(conv_fall), .rise_o(conv_rise_unused)
  );

  adc_edge_tap #(.RESET_LEVEL(1'b1)) sclk_tap_i (
    .clk(clk), .rst_n(rst_n), .level_i(ser_clk),
    .fall_o(sclk_fall), .rise_o(sclk_rise)
  );

  adc_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) timer_i (
    .clk(clk), .rst_n(rst_n), .start_req_i(conv_fall),
    .accept_o(conv_accept), .done_o(conv_done), .busy_o(busy)
  );

  adc_shift_out #(.SAMPLE_W(SAMPLE_W), .FRAME_W(FRAME_W)) shifter_i (
    .clk(clk), .rst_n(rst_n), .accept_i(conv_accept), .done_i(conv_done),
    .sample_i(sample_in), .sclk_fall_i(sclk_fall), .sclk_rise_i(sclk_rise),
    .sdata_o(sdata), .oe_o(sdata_oe)
  );
endmodule

// File: rtl/adc_serial_out_chk.sv
module adc_serial_out_chk #(
  parameter int unsigned CONV_CYCLES = 500
) (
  input logic clk,
  input logic rst_n,
  input logic conv_fall,
  input logic conv_accept,
  input logic sclk_fall,
  input logic sclk_rise,
  input logic busy,
  input logic sdata,
  input logic sdata_oe
);
  int unsigned busy_run;

  always_ff @(posedge clk) begin
    if (!rst_n) busy_run <= 0;
    else        busy_run <= busy ? busy_run + 1 : 0;
  end

  assert_busy_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_accept |=> busy);

  assert_busy_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_run == CONV_CYCLES));

  assert_busy_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(conv_fall));

  assert_ignore_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && conv_fall && busy_run < CONV_CYCLES - 1) |=> busy);

  assert_oe_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdata_oe) |-> $past(sclk_fall));

  assert_oe_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sdata_oe) |-> $past(sclk_rise || conv_accept));

  assert_conv_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    conv_accept |=> !sdata_oe);

  assert_zero_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sdata_oe) |-> !sdata);
endmodule

bind adc_serial_out adc_serial_out_chk #(.CONV_CYCLES(CONV_CYCLES)) chk_i (
  .clk(clk), .rst_n(rst_n), .conv_fall(conv_fall), .conv_accept(conv_accept),
  .sclk_fall(sclk_fall), .sclk_rise(sclk_rise), .busy(busy),
  .sdata(sdata), .sdata_oe(sdata_oe)
);

// File: tb/adc_serial_out_tb_top.sv
`timescale 1ns/1ps
module adc_serial_out_tb_top;
  localparam int CONV = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic conv_start_n = 1'b1;
  logic [13:0] sample_in = '0;
  logic ser_clk = 1'b1;
  logic busy, sdata, sdata_oe;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  adc_serial_out #(.SAMPLE_W(14), .FRAME_W(16), .CONV_CYCLES(CONV)) dut_i (
    .clk(clk), .rst_n(rst_n), .conv_start_n(conv_start_n), .sample_in(sample_in),
    .ser_clk(ser_clk), .busy(busy), .sdata(sdata), .sdata_oe(sdata_oe)
  );

  // sample, expected frame
  localparam logic [29:0] VEC [5] = '{
    {14'h3FFF, 16'h3FFF},
    {14'h0000, 16'h0000},
    {14'h2AAA, 16'h2AAA},
    {14'h1555, 16'h1555},
    {14'h2001, 16'h2001}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Starts a conversion; returns at the first falling system edge with busy expected high.
  task automatic start_conv(input logic [13:0] s, input bit keep_low);
    @(negedge clk); sample_in = s; conv_start_n = 1'b0;
    @(negedge clk); if (!keep_low) conv_start_n = 1'b1;
  endtask

  // Waits out the rest of busy, checking both ends of the window.
  task automatic finish_busy(input string req);
    check(req, 32'(busy), 1);
    repeat (CONV - 1) @(negedge clk);
    check(req, 32'(busy), 1);
    @(negedge clk);
    check(req, 32'(busy), 0);
  endtask

  task automatic pulse(output logic b, output logic oe);
    @(negedge clk); ser_clk = 1'b0;
    @(negedge clk); b = sdata; oe = sdata_oe; ser_clk = 1'b1;
  endtask

  task automatic read_bits(input int n, output logic [15:0] w, output logic oe_all);
    logic b, oe;
    w = '0; oe_all = 1'b1;
    for (int i = 0; i < n; i++) begin
      pulse(b, oe);
      w = {w[14:0], b};
      oe_all &= oe;
    end
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] w;
    logic oe_all, b, oe;

    repeat (3) @(negedge clk);
    // R1 reset values
    check("R1 busy", 32'(busy), 0);
    check("R1 sdata", 32'(sdata), 0);
    check("R1 oe", 32'(sdata_oe), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table: R2 busy length, R3 frame content, R5 oe window
    for (int v = 0; v < 5; v++) begin
      start_conv(VEC[v][29:16], 1'b0);
      finish_busy("R2");
      read_bits(16, w, oe_all);
      check("R3 frame", 32'(w), 32'(VEC[v][15:0]));
      check("R5 oe during read", 32'(oe_all), 1);
      @(negedge clk);
      check("R5 oe after 16", 32'(sdata_oe), 0);
    end

    // R4 and R7: sample change and second edge during busy ignored
    start_conv(14'h1234, 1'b0);
    repeat (10) @(negedge clk);
    sample_in = 14'h0F0F; conv_start_n = 1'b0;
    @(negedge clk); conv_start_n = 1'b1;
    check("R7 busy held", 32'(busy), 1);
    repeat (CONV - 12) @(negedge clk);
    check("R7 busy end unchanged", 32'(busy), 1);
    @(negedge clk);
    check("R7 busy end unchanged", 32'(busy), 0);
    read_bits(16, w, oe_all);
    check("R4 frame keeps first sample", 32'(w), 32'h1234);

    // R6: 17th pulse wraps and drives MSB again
    start_conv(14'h3FFF, 1'b0);
    finish_busy("R2");
    read_bits(16, w, oe_all);
    pulse(b, oe);
    check("R6 oe on 17th", 32'(oe), 1);
    check("R6 bit15 on 17th", 32'(b), 0);
    pulse(b, oe);
    pulse(b, oe);
    check("R6 bit13 on 19th", 32'(b), 1);

    // R8 and R9: convert-start in the middle of a read
    start_conv(14'h2AAA, 1'b0);
    finish_busy("R2");
    read_bits(5, w, oe_all);
    check("R3 partial", 32'(w[4:0]), 32'(5'b00101));
    start_conv(14'h3C3C, 1'b0);
    check("R8 oe cleared", 32'(sdata_oe), 0);
    read_bits(3, w, oe_all);
    check("R9 zeros during busy", 32'(w[2:0]), 0);
    check("R9 driven during busy", 32'(oe_all), 1);
    while (busy) @(negedge clk);
    read_bits(13, w, oe_all);
    check("R8 remaining bits", 32'(w[12:0]), 32'(16'h3C3C & 16'h1FFF));
    @(negedge clk);
    check("R8 oe after wrap", 32'(sdata_oe), 0);

    // R10: held-low convert start does not retrigger
    start_conv(14'h0001, 1'b1);
    finish_busy("R10");
    repeat (CONV) @(negedge clk);
    check("R10 no retrigger", 32'(busy), 0);
    conv_start_n = 1'b1;
    @(negedge clk);
    check("R10 rising edge only", 32'(busy), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule